// File: doc/BRIEF.md
# Compressed Block Address Translator

This block turns a real (pre-compression) address into the physical locations that hold the compressed copy of its 1 KB block. Memory holds a direct-mapped translation table. It starts at physical address zero and has one 16-byte entry per 1 KB real block. For each accepted request the block works out where the entry sits, reads those 16 bytes over a simple request/response memory port, and decodes the entry.

The top byte of an entry is a status field. It carries an inline flag, an uncompressed-mode flag and a sector count. The lower 120 bits hold four 30-bit sector indices, or, for an inline block, the compressed data itself. The translator sends its result as a stream of beats over a valid/ready output. A normal block gives one beat per sector in use, carrying that sector's byte address. An inline block gives a single beat that carries the embedded data. A block with no sectors and no inline data gives a single "empty" beat.

Only one translation is in flight at a time. The requester sees ready again only after the final beat of the current translation has been taken.

Top module: `cbt_translator`

## Requirements
- R1: For a request with real address A, exactly one entry read is issued, at physical address 0 + floor(A / 1024) * 16. The low ten address bits do not affect it. The read address stays constant while the read waits for `mem_rd_ready`.
- R2: The sector count is entry bits [122:120]. For a non-inline entry with count N in 1..4, exactly N beats of kind SECTOR (`out_kind` = 0) are sent. Beat i carries index i, taken from entry bits [30*i+29 : 30*i], and `out_addr` = index * 256. Beats go out in order i = 0,1,2,3. `out_last` is set only on the final beat, and pointers at or above N produce no beat.
- R3: A count field of 5, 6 or 7 is treated as 4.
- R4: When entry bit 127 (inline) is set, exactly one beat of kind INLINE (`out_kind` = 1) is sent, whatever the count field holds. It has `out_last` = 1, `out_payload` = entry bits [119:0] and `out_addr` = 0, and no sector beat is sent.
- R5: A non-inline entry with count 0 gives exactly one beat of kind EMPTY (`out_kind` = 2), with `out_last` = 1 and `out_addr` = 0.
- R6: `out_raw` equals entry bit 126 on every beat of the translation. Entry bits [125:123] have no effect on any output.
- R7: While `out_valid` is high and `out_ready` is low, the beat stays in place: `out_valid`, `out_kind`, `out_addr` and `out_last` remain unchanged in the next cycle.
- R8: `req_ready` is high only when no translation is in progress. A request held at the input while beats are being sent is not taken in the cycle the final beat is handed off. It is taken at the next clock edge.
- R9: After reset, `req_ready` is 1 and `mem_rd_valid` and `out_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Translator idle and taking a request |
| req_raddr | input | RADDR_W | Real address to translate |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_ready | input | 1 | Memory took the entry read |
| mem_rd_addr | output | PADDR_W | Physical byte address of the 16-byte entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 128 | The 16-byte table entry |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_kind | output | 2 | 0 sector, 1 inline, 2 empty |
| out_addr | output | PADDR_W | Sector byte address (0 for inline or empty) |
| out_payload | output | 120 | Inline data (0 on other beats) |
| out_raw | output | 1 | Block stored uncompressed |
| out_last | output | 1 | Final beat of the translation |

## Verification
Two events can land on the same clock edge: the handoff of a translation's final beat, and a new request that the requester has been holding at the input. The bench provokes this by leaving `req_valid` high with the next address for the whole of a translation. It runs this under several backpressure patterns. At every sampled cycle where a beat is present, it requires `req_ready` to be low. It then checks that the next entry read carries the table address of the held request and occurs only after the final beat has gone.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  localparam int ENTRY_W      = 128;
  localparam int ENTRY_SHIFT  = 4;   // 16-byte entries
  localparam int BLOCK_SHIFT  = 10;  // 1 KB real blocks
  localparam int SECTOR_SHIFT = 8;   // 256-byte sectors
  localparam int NUM_PTR      = 4;
  localparam int PTR_W        = 30;
  localparam int PAYLOAD_W    = NUM_PTR * PTR_W;
  localparam int CNT_W        = 3;
  localparam int IDX_W        = $clog2(NUM_PTR);

  typedef enum logic [1:0] {
    BEAT_SECTOR = 2'd0,
    BEAT_INLINE = 2'd1,
    BEAT_EMPTY  = 2'd2
  } beat_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT,
    ST_EMIT
  } xl_state_e;

  function automatic logic [CNT_W-1:0] clamp_count(input logic [CNT_W-1:0] c);
    return (c > CNT_W'(NUM_PTR)) ? CNT_W'(NUM_PTR) : c;
  endfunction

  function automatic beat_kind_e pick_kind(input logic inl, input logic [CNT_W-1:0] used);
    if (inl) return BEAT_INLINE;
    if (used == '0) return BEAT_EMPTY;
    return BEAT_SECTOR;
  endfunction
endpackage

// File: rtl/cbt_entry_addr.sv
module cbt_entry_addr
  import cbt_pkg::*;
#(
  parameter int RADDR_W = 32,
  parameter int PADDR_W = 40,
  parameter logic [PADDR_W-1:0] TBL_BASE = '0
) (
  input  logic [RADDR_W-1:0] raddr,
  output logic [PADDR_W-1:0] entry_addr
);
  localparam int BLK_W = RADDR_W - BLOCK_SHIFT;

  function automatic logic [PADDR_W-1:0] table_slot(input logic [BLK_W-1:0] blk);
    return TBL_BASE + (PADDR_W'(blk) << ENTRY_SHIFT);
  endfunction

  logic [BLK_W-1:0]       blk_num;
  logic [BLOCK_SHIFT-1:0] unused_offset;

  assign blk_num       = raddr[RADDR_W-1:BLOCK_SHIFT];
  assign unused_offset = raddr[BLOCK_SHIFT-1:0];
  assign entry_addr    = table_slot(blk_num);
endmodule

// File: rtl/cbt_entry_decode.sv
module cbt_entry_decode
  import cbt_pkg::*;
(
  input  logic [ENTRY_W-1:0]              entry,
  output logic                            is_inline,
  output logic                            is_raw,
  output logic [CNT_W-1:0]                used,
  output logic [NUM_PTR-1:0][PTR_W-1:0]   ptrs,
  output logic [PAYLOAD_W-1:0]            payload
);
  localparam int STAT_LSB = PAYLOAD_W;

  logic unused_status;

  assign is_inline     = entry[ENTRY_W-1];
  assign is_raw        = entry[ENTRY_W-2];
  assign used          = clamp_count(entry[STAT_LSB+CNT_W-1:STAT_LSB]);
  assign payload       = entry[PAYLOAD_W-1:0];
  assign unused_status = ^entry[ENTRY_W-3:STAT_LSB+CNT_W];

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    assign ptrs[g] = entry[g*PTR_W +: PTR_W];
  end
endmodule

// File: rtl/cbt_beat_seq.sv
module cbt_beat_seq
  import cbt_pkg::*;
#(
  parameter int PADDR_W = 40
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          active,
  input  logic                          beat_fire,
  input  logic                          is_inline,
  input  logic [CNT_W-1:0]              used,
  input  logic [NUM_PTR-1:0][PTR_W-1:0] ptrs,
  input  logic [PAYLOAD_W-1:0]          payload,
  output beat_kind_e                    kind,
  output logic [PADDR_W-1:0]            addr,
  output logic [PAYLOAD_W-1:0]          beat_payload,
  output logic                          last
);
  logic [IDX_W-1:0] idx_q;
  logic             sector_beat;

  function automatic logic [PADDR_W-1:0] sector_byte_addr(input logic [PTR_W-1:0] p);
    return PADDR_W'(p) << SECTOR_SHIFT;
  endfunction

  assign kind         = pick_kind(is_inline, used);
  assign sector_beat  = (kind == BEAT_SECTOR);
  assign addr         = sector_beat ? sector_byte_addr(ptrs[idx_q]) : '0;
  assign beat_payload = (kind == BEAT_INLINE) ? payload : '0;
  assign last         = !sector_beat || ({1'b0, idx_q} == used - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (start) begin
      idx_q <= '0;
    end else if (beat_fire && !last) begin
      idx_q <= idx_q + IDX_W'(1);
    end
  end

  // R2: the pointer in use never reaches past the valid count
  a_r2_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (active && sector_beat) |-> ({1'b0, idx_q} < used));

  // R2: a non-final beat always advances to the next pointer
  a_r2_idx_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (active && beat_fire && !last) |=> (idx_q != $past(idx_q)));
endmodule

// File: rtl/cbt_translator.sv
module cbt_translator
  import cbt_pkg::*;
#(
  parameter int RADDR_W = 32,
  parameter int PADDR_W = 40,
  parameter logic [PADDR_W-1:0] TBL_BASE = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [RADDR_W-1:0]   req_raddr,
  output logic                 mem_rd_valid,
  input  logic                 mem_rd_ready,
  output logic [PADDR_W-1:0]   mem_rd_addr,
  input  logic                 mem_rsp_valid,
  input  logic [ENTRY_W-1:0]   mem_rsp_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [1:0]           out_kind,
  output logic [PADDR_W-1:0]   out_addr,
  output logic [PAYLOAD_W-1:0] out_payload,
  output logic                 out_raw,
  output logic                 out_last
);
  xl_state_e             state_q;
  logic [RADDR_W-1:0]    raddr_q;
  logic [ENTRY_W-1:0]    entry_q;

  // named events
  logic req_fire, rd_fire, rsp_take, beat_fire, xl_done;

  logic                          dec_inline, dec_raw;
  logic [CNT_W-1:0]              dec_used;
  logic [NUM_PTR-1:0][PTR_W-1:0] dec_ptrs;
  logic [PAYLOAD_W-1:0]          dec_payload;
  beat_kind_e                    seq_kind;
  logic                          seq_last;

  assign req_ready    = (state_q == ST_IDLE);
  assign mem_rd_valid = (state_q == ST_READ);
  assign out_valid    = (state_q == ST_EMIT);

  assign req_fire  = req_ready && req_valid;
  assign rd_fire   = mem_rd_valid && mem_rd_ready;
  assign rsp_take  = (state_q == ST_WAIT) && mem_rsp_valid;
  assign beat_fire = out_valid && out_ready;
  assign xl_done   = beat_fire && seq_last;

  cbt_entry_addr #(
    .RADDR_W (RADDR_W),
    .PADDR_W (PADDR_W),
    .TBL_BASE(TBL_BASE)
  ) u_addr (
    .raddr     (raddr_q),
    .entry_addr(mem_rd_addr)
  );

  cbt_entry_decode u_dec (
    .entry    (entry_q),
    .is_inline(dec_inline),
    .is_raw   (dec_raw),
    .used     (dec_used),
    .ptrs     (dec_ptrs),
    .payload  (dec_payload)
  );

  cbt_beat_seq #(
    .PADDR_W(PADDR_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (rsp_take),
    .active      (out_valid),
    .beat_fire   (beat_fire),
    .is_inline   (dec_inline),
    .used        (dec_used),
    .ptrs        (dec_ptrs),
    .payload     (dec_payload),
    .kind        (seq_kind),
    .addr        (out_addr),
    .beat_payload(out_payload),
    .last        (seq_last)
  );

  assign out_kind = seq_kind;
  assign out_raw  = dec_raw;
  assign out_last = seq_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      raddr_q <= '0;
      entry_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_fire) begin
          raddr_q <= req_raddr;
          state_q <= ST_READ;
        end
        ST_READ: if (rd_fire) state_q <= ST_WAIT;
        ST_WAIT: if (rsp_take) begin
          entry_q <= mem_rsp_data;
          state_q <= ST_EMIT;
        end
        ST_EMIT: if (xl_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8: an idle translator has neither a read nor a beat outstanding
  a_r8_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_rd_valid && !out_valid));

  // R8: the edge that hands off the final beat does not also take a request
  a_r8_no_accept_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |-> !req_ready);

  // R1: a stalled entry read keeps its address
  a_r1_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  // R1: entry reads land on 16-byte slots of the table
  a_r1_rd_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> (mem_rd_addr[ENTRY_SHIFT-1:0] == TBL_BASE[ENTRY_SHIFT-1:0]));

  // R7: a beat under backpressure stays in place
  a_r7_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) &&
                                   $stable(out_kind) && $stable(out_last)));

  // R4, R5: inline and empty results are single-beat
  a_r4_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind != 2'd0) |-> (out_last && out_addr == '0));

  // R2: sector addresses are 256-byte aligned
  a_r2_sector_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == 2'd0) |-> (out_addr[SECTOR_SHIFT-1:0] == '0));

  // R6: the mode flag does not change within a translation
  a_r6_raw_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> $stable(out_raw));
endmodule

// File: tb/sim_cbt_translator.sv
module sim_cbt_translator;
  localparam int RA_W = 16;
  localparam int PA_W = 40;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req_valid = 1'b0;
  logic           req_ready;
  logic [RA_W-1:0] req_raddr = '0;
  logic           mem_rd_valid;
  logic           mem_rd_ready = 1'b0;
  logic [PA_W-1:0] mem_rd_addr;
  logic           mem_rsp_valid = 1'b0;
  logic [127:0]   mem_rsp_data = '0;
  logic           out_valid;
  logic           out_ready = 1'b0;
  logic [1:0]     out_kind;
  logic [PA_W-1:0] out_addr;
  logic [119:0]   out_payload;
  logic           out_raw;
  logic           out_last;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  cbt_translator #(.RADDR_W(RA_W), .PADDR_W(PA_W)) u0 (
    .clk, .rst_n, .req_valid, .req_ready, .req_raddr,
    .mem_rd_valid, .mem_rd_ready, .mem_rd_addr, .mem_rsp_valid, .mem_rsp_data,
    .out_valid, .out_ready, .out_kind, .out_addr, .out_payload, .out_raw, .out_last
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [29:0] ptr_val(input int seed, input int i);
    logic [31:0] x;
    x = 32'(seed) * 32'd2654435761 + 32'(i) * 32'd40503 + 32'd977;
    return x[31:2];
  endfunction

  function automatic logic [127:0] mk_entry(input bit inl, input bit raw,
                                            input int cnt, input int seed);
    logic [127:0] e;
    e = '0;
    for (int i = 0; i < 4; i++) e[i*30 +: 30] = ptr_val(seed, i);
    e[127] = inl;
    e[126] = raw;
    e[125:123] = 3'(seed);      // ignored bits (R6)
    e[122:120] = 3'(cnt);
    return e;
  endfunction

  function automatic bit stall_ready(input int mode, input int cyc);
    case (mode)
      0: return 1'b1;
      1: return (cyc % 2) == 1;
      default: return (cyc % 3) == 2;
    endcase
  endfunction

  // keep_req: after acceptance hold req_valid high with next_ra (R8 scenario)
  task automatic run_one(input logic [RA_W-1:0] ra, input logic [127:0] ent,
                         input int dly, input int stall,
                         input bit keep_req, input logic [RA_W-1:0] next_ra);
    logic [PA_W-1:0] exp_ea;
    int cnt, nb, b, cyc;
    bit inl, stalled;
    logic [PA_W-1:0] p_addr;
    logic [1:0] p_kind;
    logic p_last;
    logic [1:0] e_kind;
    logic [PA_W-1:0] e_addr;
    logic [119:0] e_pay;

    exp_ea = PA_W'(ra / 1024) * 16;
    inl = ent[127];
    cnt = int'(ent[122:120]);
    if (cnt > 4) cnt = 4;                  // R3
    nb = (inl || cnt == 0) ? 1 : cnt;

    req_valid = 1'b1;
    req_raddr = ra;
    cyc = 0;
    while (!req_ready) begin @(negedge clk); cyc++; end
    @(negedge clk);
    if (keep_req) req_raddr = next_ra; else req_valid = 1'b0;

    while (!mem_rd_valid) @(negedge clk);
    chk(mem_rd_addr == exp_ea, "R1", "entry address", 128'(mem_rd_addr), 128'(exp_ea));
    for (int d = 0; d < dly; d++) begin
      @(negedge clk);
      chk(mem_rd_valid && mem_rd_addr == exp_ea, "R1", "read held", 128'(mem_rd_addr), 128'(exp_ea));
    end
    mem_rd_ready = 1'b1;
    @(negedge clk);
    mem_rd_ready = 1'b0;
    for (int d = 0; d < dly; d++) @(negedge clk);
    chk(!mem_rd_valid && !out_valid, "R1", "single read, no early beat",
        128'({mem_rd_valid, out_valid}), 128'(0));
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = ent;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = ~ent;

    b = 0; cyc = 0; stalled = 1'b0;
    p_addr = '0; p_kind = '0; p_last = 1'b0;
    while (b < nb && cyc < 100) begin
      out_ready = stall_ready(stall, cyc);
      if (stalled)
        chk(out_valid && out_addr == p_addr && out_kind == p_kind && out_last == p_last,
            "R7", "beat held", 128'(out_addr), 128'(p_addr));
      stalled = 1'b0;
      if (out_valid) begin
        if (keep_req) chk(!req_ready, "R8", "ready low while busy", 128'(req_ready), 128'(0));
        if (out_ready) begin
          if (inl) begin e_kind = 2'd1; e_addr = '0; e_pay = ent[119:0]; end
          else if (cnt == 0) begin e_kind = 2'd2; e_addr = '0; e_pay = '0; end
          else begin
            e_kind = 2'd0; e_pay = '0;
            e_addr = PA_W'(ptr_val(0, 0)) & '0;
            e_addr = PA_W'(ent[b*30 +: 30]) * 256;
          end
          chk(out_kind == e_kind, inl ? "R4" : (cnt == 0 ? "R5" : "R2"), "kind",
              128'(out_kind), 128'(e_kind));
          chk(out_addr == e_addr, (cnt > 0 && !inl) ? "R2" : "R5", "addr",
              128'(out_addr), 128'(e_addr));
          chk(out_payload == e_pay, "R4", "payload", 128'(out_payload), 128'(e_pay));
          chk(out_last == (b == nb - 1), "R2", "last flag", 128'(out_last), 128'(b == nb - 1));
          chk(out_raw == ent[126], "R6", "raw flag", 128'(out_raw), 128'(ent[126]));
          b++;
        end else begin
          stalled = 1'b1;
          p_addr = out_addr; p_kind = out_kind; p_last = out_last;
        end
      end
      @(negedge clk);
      cyc++;
    end
    out_ready = 1'b0;
    chk(b == nb, "R2", "beat count", 128'(b), 128'(nb));
    chk(!out_valid, "R2", "no extra beat after last", 128'(out_valid), 128'(0));
    chk(req_ready, "R8", "ready after final handoff", 128'(req_ready), 128'(1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R9", "reset req_ready", 128'(req_ready), 128'(1));
    chk(mem_rd_valid == 1'b0, "R9", "reset mem_rd_valid", 128'(mem_rd_valid), 128'(0));
    chk(out_valid == 1'b0, "R9", "reset out_valid", 128'(out_valid), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);

    // sweep every block of the small address space
    for (int blk = 0; blk < 64; blk++) begin
      run_one(RA_W'(blk * 1024 + ((blk * 13) % 1024)),
              mk_entry((blk % 5) == 4, blk[1], blk % 8, blk),
              blk % 3, blk % 3, 1'b0, '0);
    end

    // exhaustive over status combinations (R3, R4, R5, R6)
    for (int s = 0; s < 32; s++) begin
      run_one(RA_W'(16'h2c00 + s), mk_entry(s[4], s[3], s % 8, s + 100),
              s % 2, s % 3, 1'b0, '0);
    end

    // held request across the final handoff (R8)
    for (int k = 0; k < 12; k++) begin
      run_one(RA_W'((k * 5 % 64) * 1024 + k), mk_entry(k == 7, k[0], (k % 5) + 1, k + 300),
              k % 3, k % 3, 1'b1, RA_W'((((k + 1) * 5) % 64) * 1024 + k + 1));
    end
    run_one(RA_W'(((12 * 5) % 64) * 1024 + 12), mk_entry(1'b0, 1'b0, 3, 400),
            0, 1, 1'b0, '0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule